// File: doc/BRIEF.md
# S/PDIF Channel-Status Capture Bank

This block sits behind an S/PDIF receiver's biphase decoder and preamble detector. For every decoded subframe it is given a strobe, a flag saying whether the subframe belongs to channel A or channel B, a flag marking the first frame of a 192-frame block, and the channel-status bit carried by that subframe. It keeps only the subframes of one channel, chosen by a control input. From these it assembles the full 192-bit channel-status block in a shadow store.

When the last bit of a block has landed, the whole block is copied in one step into a readable bank. A reader therefore never sees a mix of two blocks. The bank is read as 32-bit words through a 3-bit page selector. Status bit n sits in byte n/8 at bit n mod 8. Selector values past the last word return zero.

Two clear inputs control the two sides. One clears the collection side and the other clears the readable side. Software releases the readback clear first and the collection clear second. While the readback clear is held, the collection side stays idle as well. An enable input gates all capture.

Top module: `spdif_cs_capture`

## Requirements
- R1: After a synchronous active-low reset, every selector value 0 to 7 reads a zero word.
- R2: A block starts at a selected-channel subframe whose block-start flag is 1, and that subframe carries bit 0. The next 191 selected-channel subframes carry bits 1 to 191. Status bit n is stored in byte n/8 at bit position n mod 8, which is bit n of the 192-bit bank. The new block becomes readable no later than the second clock edge after its last subframe is sampled.
- R3: Only subframes whose channel flag (0 = channel A, 1 = channel B) equals `src_chan_b` are collected. Subframes of the other channel have no effect.
- R4: For `rd_sel` values 0 to 5, bits 8j+7..8j of `rd_word` hold bank byte 4*rd_sel + j, for j = 0 to 3. For `rd_sel` values 6 and 7, `rd_word` is zero.
- R5: The readable bank changes only when a complete block is committed or when it is cleared. A partial block leaves the previous contents visible.
- R6: A block-start flag on a selected subframe in the middle of a block restarts collection at bit 0 and discards the partial block.
- R7: Holding `out_clr` clears the readable bank to zero. Asserting `in_clr` during a block discards that block, so no commit follows even if the rest of its bits arrive.
- R8: Collection runs only while `cap_enable` is 1, `in_clr` is 0 and `out_clr` is 0. While `out_clr` is held, the collection side stays idle even when `in_clr` has been released.
- R9: After a block has been committed, further selected subframes are ignored until the next block-start flag arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_enable | input | 1 | Capture enable |
| src_chan_b | input | 1 | Source channel: 0 = A, 1 = B |
| in_clr | input | 1 | Clear of the collection side |
| out_clr | input | 1 | Clear of the readable bank |
| sf_valid | input | 1 | Subframe strobe, one cycle per subframe |
| sf_chan_b | input | 1 | Subframe channel flag: 0 = A, 1 = B |
| sf_block_start | input | 1 | Subframe belongs to the first frame of a block |
| sf_cs_bit | input | 1 | Channel-status bit of the subframe |
| rd_sel | input | 3 | Word selector |
| rd_word | output | 32 | Selected 32-bit status word |

## Verification
The bench uses the default parameters: 192 status bits, 32-bit words and a 3-bit selector. With these, all six populated words and both empty selector codes are reachable, so the zero return for codes 6 and 7 is observed. The full-length blocks drive the bit index all the way to its last value, 191, where the commit fires. At that size the bench also reaches the overrun window after a commit and the restart of a block partway through it.

// File: rtl/spdif_cs_pkg.sv
// Shared types for the channel-status capture bank.
// Assumes one subframe strobe per cycle at most.
package spdif_cs_pkg;

    typedef struct packed {
        logic valid;      // subframe strobe
        logic is_b;       // channel flag, 1 = channel B
        logic blk_start;  // first frame of a 192-frame block
        logic cs_bit;     // channel-status bit
    } subframe_t;

endpackage

// File: rtl/cs_bit_collector.sv
// Collects the status bits of the selected channel into a shadow store.
// Raises commit_o for one cycle once the last bit of a block has been written.
// Assumes NUM_BITS > 1. Idle (not synced) until a block-start subframe is seen.
module cs_bit_collector
    import spdif_cs_pkg::*;
#(
    parameter int NUM_BITS = 192,
    localparam int IDX_W   = $clog2(NUM_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                src_b,
    input  subframe_t           sf,
    output logic [NUM_BITS-1:0] shadow_o,
    output logic                commit_o
);

    logic [IDX_W-1:0]    idx_q;
    logic                synced_q;
    logic [NUM_BITS-1:0] shadow_q;
    logic                commit_q;
    logic                take;
    logic                last_wr;

    // Decide whether this subframe is collected and whether it closes a block.
    always_comb begin
        take    = active && sf.valid && (sf.is_b == src_b);
        last_wr = take && !sf.blk_start && synced_q &&
                  (idx_q == IDX_W'(NUM_BITS - 1));
    end

    // Bit index, sync flag, shadow store and commit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            synced_q <= 1'b0;
            shadow_q <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= last_wr;
            if (!active) begin
                idx_q    <= '0;
                synced_q <= 1'b0;
            end else if (take) begin
                if (sf.blk_start) begin
                    shadow_q[0] <= sf.cs_bit;
                    idx_q       <= IDX_W'(1);
                    synced_q    <= 1'b1;
                end else if (synced_q) begin
                    shadow_q[idx_q] <= sf.cs_bit;
                    idx_q           <= idx_q + IDX_W'(1);
                    if (last_wr) begin
                        synced_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign shadow_o = shadow_q;
    assign commit_o = commit_q;

    // R6: a selected block-start subframe restarts the index at bit 1 next.
    a_r6_restart_index: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sf.blk_start) |=> (idx_q == IDX_W'(1) && synced_q));

    // R9: a commit is a single-cycle strobe, and the sync flag drops with it.
    a_r9_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> !commit_q);

    a_r9_unsynced_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> !synced_q);

    // R8: an inactive collection side forgets any block in progress.
    a_r8_idle_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (idx_q == '0 && !synced_q && !commit_q));

endmodule

// File: rtl/cs_block_store.sv
// Readable bank: loads a whole shadow block on load_i, clears on clr_i.
// Assumes load_i is a single-cycle strobe from the collector.
module cs_block_store #(
    parameter int NUM_BITS = 192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                load_i,
    input  logic [NUM_BITS-1:0] shadow_i,
    output logic [NUM_BITS-1:0] bank_o
);

    logic [NUM_BITS-1:0] bank_q;

    // Copy a complete block, or clear; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            bank_q <= '0;
        end else if (load_i) begin
            bank_q <= shadow_i;
        end
    end

    assign bank_o = bank_q;

    // R7: a readback clear empties the bank by the next cycle.
    a_r7_clear_bank: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (bank_q == '0));

    // R5: without a commit or clear, the bank holds its value.
    a_r5_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !load_i) |=> $stable(bank_q));

endmodule

// File: rtl/cs_word_mux.sv
// Pages the bank out as WORD_W-bit words; codes past the last word read zero.
// Assumes NUM_BITS is a multiple of WORD_W and fits in 2**SEL_W words.
module cs_word_mux #(
    parameter int NUM_BITS  = 192,
    parameter int WORD_W    = 32,
    parameter int SEL_W     = 3,
    localparam int NUM_WORDS = NUM_BITS / WORD_W,
    localparam int NUM_PAGES = 1 << SEL_W
) (
    input  logic [NUM_BITS-1:0] bank_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic [WORD_W-1:0]   word_o
);

    logic [WORD_W-1:0] pages [NUM_PAGES];

    // One slot per selector code: populated words first, zero after.
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        if (g < NUM_WORDS) begin : g_fill
            assign pages[g] = bank_i[g*WORD_W +: WORD_W];
        end else begin : g_empty
            assign pages[g] = '0;
        end
    end

    // Select the requested page.
    always_comb begin
        word_o = pages[sel_i];
    end

endmodule

// File: rtl/spdif_cs_capture.sv
// Top of the channel-status capture bank: gates collection, commits whole
// blocks into the readable bank and pages the bank out as words.
// Assumes the readback clear is released before the collection clear.
module spdif_cs_capture
    import spdif_cs_pkg::*;
#(
    parameter int CS_BITS = 192,
    parameter int WORD_W  = 32,
    parameter int SEL_W   = 3,
    localparam int NUM_WORDS = CS_BITS / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_enable,
    input  logic              src_chan_b,
    input  logic              in_clr,
    input  logic              out_clr,
    input  logic              sf_valid,
    input  logic              sf_chan_b,
    input  logic              sf_block_start,
    input  logic              sf_cs_bit,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_word
);

    subframe_t          sf;
    logic               cap_active;
    logic [CS_BITS-1:0] shadow;
    logic               commit;
    logic [CS_BITS-1:0] bank;

    // Bundle the subframe and derive the collection gate.
    always_comb begin
        sf         = '{valid: sf_valid, is_b: sf_chan_b,
                       blk_start: sf_block_start, cs_bit: sf_cs_bit};
        cap_active = cap_enable && !in_clr && !out_clr;
    end

    cs_bit_collector #(.NUM_BITS(CS_BITS)) collector_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (cap_active),
        .src_b    (src_chan_b),
        .sf       (sf),
        .shadow_o (shadow),
        .commit_o (commit)
    );

    cs_block_store #(.NUM_BITS(CS_BITS)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (out_clr),
        .load_i   (commit),
        .shadow_i (shadow),
        .bank_o   (bank)
    );

    cs_word_mux #(.NUM_BITS(CS_BITS), .WORD_W(WORD_W), .SEL_W(SEL_W)) mux_i (
        .bank_i (bank),
        .sel_i  (rd_sel),
        .word_o (rd_word)
    );

    // R4: selector codes beyond the last word read zero.
    a_r4_high_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel) >= NUM_WORDS) |-> (rd_word == '0));

    // R8: a held readback clear keeps the collection side idle.
    a_r8_out_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (out_clr || !cap_enable) |=> !commit);

endmodule

// File: tb/spdif_cs_capture_tb_top.sv
module spdif_cs_capture_tb_top;

    localparam int NB = 192;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cap_enable, src_chan_b, in_clr, out_clr;
    logic        sf_valid, sf_chan_b, sf_block_start, sf_cs_bit;
    logic [2:0]  rd_sel;
    logic [31:0] rd_word;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [NB-1:0] exp_bank;

    always #2 clk = ~clk;

    spdif_cs_capture dut_i (
        .clk(clk), .rst_n(rst_n), .cap_enable(cap_enable),
        .src_chan_b(src_chan_b), .in_clr(in_clr), .out_clr(out_clr),
        .sf_valid(sf_valid), .sf_chan_b(sf_chan_b),
        .sf_block_start(sf_block_start), .sf_cs_bit(sf_cs_bit),
        .rd_sel(rd_sel), .rd_word(rd_word)
    );

    // Table: {source is B, seed for channel A, seed for channel B}
    localparam logic [64:0] VEC [4] = '{
        {1'b0, 32'hA5C3_0F1E, 32'h1234_5678},
        {1'b1, 32'h0BAD_F00D, 32'hDEAD_BEEF},
        {1'b0, 32'hFFFF_0000, 32'h0000_FFFF},
        {1'b1, 32'h8001_7FFE, 32'h5A5A_C3C3}
    };

    function automatic logic gen(logic [31:0] seed, int n);
        return seed[(n * 7 + n / 32) % 32] ^ (n % 3 == 0);
    endfunction

    function automatic logic [NB-1:0] blk(logic [31:0] seed);
        logic [NB-1:0] v;
        for (int n = 0; n < NB; n++) v[n] = gen(seed, n);
        return v;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sf_valid = 1'b0; sf_block_start = 1'b0;
        end
    endtask

    task automatic send_sub(logic is_b, logic start, logic b);
        @(negedge clk);
        sf_valid = 1'b1; sf_chan_b = is_b; sf_block_start = start; sf_cs_bit = b;
    endtask

    // Frames first..last, A then B; block-start on the first frame if asked.
    task automatic send_frames(logic [31:0] sa, logic [31:0] sb,
                               int first, int last, logic with_start);
        for (int n = first; n <= last; n++) begin
            send_sub(1'b0, with_start && n == first, gen(sa, n));
            send_sub(1'b1, with_start && n == first, gen(sb, n));
        end
        idle(3);
    endtask

    task automatic check_all(string tag);
        for (int s = 0; s < 8; s++) begin
            logic [31:0] e;
            @(negedge clk);
            rd_sel = 3'(s);
            #1;
            e = (s < 6) ? exp_bank[s*32 +: 32] : 32'h0;
            checks++;
            if (rd_word !== e) begin
                errors++;
                $display("FAIL %s sel=%0d: actual %08h expected %08h", tag, s, rd_word, e);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; cap_enable = 1'b1; src_chan_b = 1'b0;
        in_clr = 1'b0; out_clr = 1'b0; sf_valid = 1'b0; sf_chan_b = 1'b0;
        sf_block_start = 1'b0; sf_cs_bit = 1'b0; rd_sel = '0;
        exp_bank = '0;
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        check_all("R1");

        // Table walk: full blocks on both channels, selected one lands (R2, R3, R4).
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); src_chan_b = VEC[v][64];
            send_frames(VEC[v][63:32], VEC[v][31:0], 0, NB - 1, 1'b1);
            exp_bank = blk(VEC[v][64] ? VEC[v][31:0] : VEC[v][63:32]);
            check_all(v[0] ? "R3" : "R2");
        end
        check_all("R4");

        // R5: partial block keeps previous contents.
        @(negedge clk); src_chan_b = 1'b0;
        send_frames(32'h1357_9BDF, 32'h2468_ACE0, 0, 99, 1'b1);
        check_all("R5");

        // R6: restart mid-block, then a full block commits only the new one.
        send_frames(32'hC0FF_EE11, 32'h0, 0, NB - 1, 1'b1);
        exp_bank = blk(32'hC0FF_EE11);
        check_all("R6");

        // R9: trailing bits without a new block start are ignored.
        send_frames(32'h7777_1111, 32'h0, 0, NB - 1, 1'b0);
        check_all("R9");
        send_frames(32'h3C3C_9696, 32'h0, 0, NB - 1, 1'b1);
        exp_bank = blk(32'h3C3C_9696);
        check_all("R9");

        // R7: collection clear mid-block discards the block.
        send_frames(32'h4242_4242, 32'h0, 0, 99, 1'b1);
        @(negedge clk); in_clr = 1'b1;
        @(negedge clk); in_clr = 1'b0;
        send_frames(32'h4242_4242, 32'h0, 100, NB - 1, 1'b0);
        check_all("R7");
        @(negedge clk); out_clr = 1'b1;
        @(negedge clk); out_clr = 1'b0;
        exp_bank = '0;
        check_all("R7");

        // R8: disabled, readback clear held, collection clear held.
        @(negedge clk); cap_enable = 1'b0;
        send_frames(32'h6B6B_1234, 32'h0, 0, NB - 1, 1'b1);
        check_all("R8");
        @(negedge clk); cap_enable = 1'b1; out_clr = 1'b1; in_clr = 1'b0;
        send_frames(32'h6B6B_1234, 32'h0, 0, NB - 1, 1'b1);
        @(negedge clk); out_clr = 1'b0;
        check_all("R8");
        @(negedge clk); in_clr = 1'b1;
        send_frames(32'h6B6B_1234, 32'h0, 0, NB - 1, 1'b1);
        check_all("R8");
        @(negedge clk); in_clr = 1'b0;
        send_frames(32'h6B6B_1234, 32'h0, 0, NB - 1, 1'b1);
        exp_bank = blk(32'h6B6B_1234);
        check_all("R8");

        // R1: reset in the middle of operation clears the bank.
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        exp_bank = '0;
        check_all("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule